// File: doc/BRIEF.md
# Flash Chip-Select Window Decoder

This block matches each host access against a small bank of programmable chip-select window registers and reports which flash window, if any, the access falls into. Every window register is 64 bits wide and carries three flags (window on, device is NAND, window lives in memory space) together with a base and a compare mask. Where the base and mask sit inside the register depends on the window's space flag. A window covers a large stretch of memory space or a short stretch of IO space.

The host presents an address and a space qualifier, and the decoder answers in the same cycle. It drives a one-hot hit vector, a flag that tells whether the winning window is a NAND device, and the offset of the access inside that window. Software loads the window registers through a simple indexed write port. A write takes effect at the next clock edge.

Top module: `csd_decoder`

## Requirements
- R1: After reset every window register reads as zero, so no access produces a hit, the NAND flag is 0 and the offset is 0.
- R2: A window whose bit 32 (on) is clear never hits, whatever its other fields and the access are.
- R3: A window hits only when its bit 34 equals `host_space` (1 = memory access, 0 = IO access).
- R4: A memory-space window compares `host_addr[31:12]` with its register bits 31:12, using register bits 63:44 as a per-bit mask. Address bits whose mask bit is 0 are ignored.
- R5: An IO-space window compares `host_addr[15:4]` with its register bits 15:4, using register bits 47:36 as the mask. `host_addr[31:16]` plays no part in an IO decode.
- R6: When several windows match, only the lowest-numbered one is reported, so `cs_hit` is one-hot or all zero.
- R7: `cs_nand` equals bit 33 (1 = NAND) of the winning window, and is 0 when there is no hit.
- R8: On a memory-space hit the offset is `{host_addr[31:12] & ~mask, host_addr[11:0]}`.
- R9: On an IO-space hit the offset is `host_addr[15:4] & ~mask` placed at bits 15:4 with `host_addr[3:0]` below and zeros above. With no hit the offset is 0.
- R10: With `wr_en` high, `wr_data` replaces window `wr_idx` at the clock edge and the decode follows it from the next cycle. Other windows are not changed, and nothing changes while `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Window register write strobe |
| wr_idx | input | 2 | Window register being written |
| wr_data | input | 64 | New window register value |
| host_addr | input | 32 | Host access address |
| host_space | input | 1 | 1 = memory access, 0 = IO access |
| cs_hit | output | 4 | One-hot winning window, zero for a miss |
| cs_nand | output | 1 | Winning window is a NAND device |
| win_offset | output | 32 | Access offset inside the winning window |

## Verification
The properties take a two-valued address and space qualifier at every clock edge after reset. They also assume that the window bank changes only through the write port, one register per cycle. The stimulus holds each input steady for a full clock and changes it a little after the edge. It loads windows with overlapping bases, all-zero masks and windows of mixed spaces, so that the priority rule, the ignored address bits and the space check are all driven. Every output is compared on every falling edge with a behavioural model of the register bank and decode.

// File: rtl/csd_pkg.sv
package csd_pkg;
   localparam int CFG_W      = 64;
   localparam int HOST_AW    = 32;
   localparam int ON_BIT     = 32;
   localparam int NAND_BIT   = 33;
   localparam int MEM_BIT    = 34;
   localparam int MEM_LO     = 12;
   localparam int MEM_FW     = 20;
   localparam int MEM_MSK_LO = 44;
   localparam int IO_LO      = 4;
   localparam int IO_FW      = 12;
   localparam int IO_MSK_LO  = 36;
   localparam int IO_SPAN    = IO_LO + IO_FW;

   typedef struct packed {
      logic              on;
      logic              nand_dev;
      logic              mem;
      logic [MEM_FW-1:0] mbase;
      logic [MEM_FW-1:0] mmask;
      logic [IO_FW-1:0]  ibase;
      logic [IO_FW-1:0]  imask;
   } win_cfg_t;

   function automatic win_cfg_t unpack_cfg(input logic [CFG_W-1:0] r);
      win_cfg_t f;
      f.on       = r[ON_BIT];
      f.nand_dev = r[NAND_BIT];
      f.mem      = r[MEM_BIT];
      f.mbase    = r[MEM_LO +: MEM_FW];
      f.mmask    = r[MEM_MSK_LO +: MEM_FW];
      f.ibase    = r[IO_LO +: IO_FW];
      f.imask    = r[IO_MSK_LO +: IO_FW];
      return f;
   endfunction
endpackage

// File: rtl/csd_window.sv
module csd_window
   import csd_pkg::*;
(
   input  logic [CFG_W-1:0]   cfg,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic               host_space,
   output logic               hit,
   output logic               is_nand,
   output logic [HOST_AW-1:0] offset
);
   localparam int IO_PAD = HOST_AW - IO_SPAN;

   win_cfg_t          f;
   logic [MEM_FW-1:0] mem_field;
   logic [IO_FW-1:0]  io_field;
   logic              mem_match;
   logic              io_match;
   logic              space_ok;

   always_comb f = unpack_cfg(cfg);

   assign mem_field = host_addr[MEM_LO +: MEM_FW];
   assign io_field  = host_addr[IO_LO +: IO_FW];
   assign mem_match = ((mem_field ^ f.mbase) & f.mmask) == '0;
   assign io_match  = ((io_field ^ f.ibase) & f.imask) == '0;
   assign space_ok  = (f.mem == host_space);

   assign hit     = f.on & space_ok & (f.mem ? mem_match : io_match);
   assign is_nand = f.nand_dev;

   always_comb begin
      if (f.mem)
         offset = {mem_field & ~f.mmask, host_addr[MEM_LO-1:0]};
      else
         offset = {{IO_PAD{1'b0}}, io_field & ~f.imask, host_addr[IO_LO-1:0]};
   end
endmodule

// File: rtl/csd_prio.sv
module csd_prio #(
   parameter int N     = 4,
   parameter int SEL_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     gnt,
   output logic [SEL_W-1:0] idx,
   output logic             any
);
   always_comb begin
      gnt = '0;
      idx = '0;
      any = 1'b0;
      for (int k = 0; k < N; k++) begin
         if (req[k] && !any) begin
            gnt[k] = 1'b1;
            idx    = SEL_W'(k);
            any    = 1'b1;
         end
      end
   end
endmodule

// File: rtl/csd_decoder.sv
module csd_decoder
   import csd_pkg::*;
#(
   parameter int NUM_WIN = 4,
   parameter int SEL_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [SEL_W-1:0]   wr_idx,
   input  logic [CFG_W-1:0]   wr_data,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic               host_space,
   output logic [NUM_WIN-1:0] cs_hit,
   output logic               cs_nand,
   output logic [HOST_AW-1:0] win_offset
);
   if (NUM_WIN < 1 || NUM_WIN > 16) begin : g_bad_num
      $error("csd_decoder: NUM_WIN must lie in 1..16");
   end
   if (SEL_W < $clog2(NUM_WIN)) begin : g_bad_sel
      $error("csd_decoder: SEL_W too narrow for NUM_WIN");
   end

   logic [NUM_WIN-1:0][CFG_W-1:0]   cfg_q;
   logic [NUM_WIN-1:0]              win_hit;
   logic [NUM_WIN-1:0]              win_nand;
   logic [NUM_WIN-1:0][HOST_AW-1:0] win_off;
   logic [SEL_W-1:0]                win_idx;
   logic                            win_any;

   for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cfg_q[k] <= '0;
         else if (wr_en && wr_idx == SEL_W'(k))
            cfg_q[k] <= wr_data;
      end

      csd_window i_window (
         .cfg        (cfg_q[k]),
         .host_addr  (host_addr),
         .host_space (host_space),
         .hit        (win_hit[k]),
         .is_nand    (win_nand[k]),
         .offset     (win_off[k])
      );
   end

   csd_prio #(.N(NUM_WIN), .SEL_W(SEL_W)) i_prio (
      .req (win_hit),
      .gnt (cs_hit),
      .idx (win_idx),
      .any (win_any)
   );

   assign cs_nand    = win_any & win_nand[win_idx];
   assign win_offset = win_any ? win_off[win_idx] : '0;
endmodule

// File: rtl/csd_decoder_chk.sv
module csd_decoder_chk
   import csd_pkg::*;
#(
   parameter int NUM_WIN = 4,
   parameter int SEL_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            wr_en,
   input logic [SEL_W-1:0]                wr_idx,
   input logic [HOST_AW-1:0]              host_addr,
   input logic                            host_space,
   input logic [NUM_WIN-1:0]              cs_hit,
   input logic                            cs_nand,
   input logic [HOST_AW-1:0]              win_offset,
   input logic [NUM_WIN-1:0][CFG_W-1:0]   cfg_q
);
   assert_reset_quiet_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (cs_hit == '0 && !cs_nand && win_offset == '0));

   assert_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_hit));

   assert_nand_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cs_nand |-> (cs_hit != '0));

   assert_idle_offset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_hit == '0) |-> (win_offset == '0));

   assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg_q));

   for (genvar k = 0; k < NUM_WIN; k++) begin : g_chk
      assert_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
         cs_hit[k] |-> cfg_q[k][ON_BIT]);

      assert_space_R3: assert property (@(posedge clk) disable iff (!rst_n)
         cs_hit[k] |-> (cfg_q[k][MEM_BIT] == host_space));

      assert_mem_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (cs_hit[k] && host_space) |->
            (((host_addr[MEM_LO +: MEM_FW] ^ cfg_q[k][MEM_LO +: MEM_FW])
              & cfg_q[k][MEM_MSK_LO +: MEM_FW]) == '0));

      assert_io_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (cs_hit[k] && !host_space) |->
            (((host_addr[IO_LO +: IO_FW] ^ cfg_q[k][IO_LO +: IO_FW])
              & cfg_q[k][IO_MSK_LO +: IO_FW]) == '0));

      assert_nand_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
         cs_hit[k] |-> (cs_nand == cfg_q[k][NAND_BIT]));

      assert_other_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_idx != SEL_W'(k)) |=> $stable(cfg_q[k]));
   end
endmodule

bind csd_decoder csd_decoder_chk #(.NUM_WIN(NUM_WIN), .SEL_W(SEL_W)) i_csd_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_idx     (wr_idx),
   .host_addr  (host_addr),
   .host_space (host_space),
   .cs_hit     (cs_hit),
   .cs_nand    (cs_nand),
   .win_offset (win_offset),
   .cfg_q      (cfg_q)
);

// File: tb/test_csd_decoder.sv
`timescale 1ns/1ps
module test_csd_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_idx = '0;
   logic [63:0] wr_data = '0;
   logic [31:0] host_addr = '0;
   logic        host_space = 1'b0;
   logic [3:0]  cs_hit;
   logic        cs_nand;
   logic [31:0] win_offset;

   int    n_checks = 0;
   int    n_fails  = 0;
   bit    started  = 0;
   bit    done     = 0;
   string cur_req  = "R1";
   logic [63:0] mdl [4] = '{default: 64'h0};

   always #5 clk = ~clk;

   csd_decoder i_csd_decoder (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .host_addr(host_addr), .host_space(host_space),
      .cs_hit(cs_hit), .cs_nand(cs_nand), .win_offset(win_offset)
   );

   // behavioural register bank
   always @(posedge clk) begin
      started <= 1'b1;
      if (!rst_n) for (int i = 0; i < 4; i++) mdl[i] <= 64'h0;
      else if (wr_en) mdl[wr_idx] <= wr_data;
   end

   function automatic void predict(input logic [31:0] a, input logic sp,
                                   output logic [3:0] h, output logic n, output logic [31:0] o);
      longint unsigned r, fb, fm, fa;
      h = 4'b0; n = 1'b0; o = 32'h0;
      for (int i = 0; i < 4; i++) begin
         r = mdl[i];
         if (h == 4'b0 && r[32] && (r[34] == sp)) begin
            if (sp) begin
               fb = (r >> 12) & 64'hFFFFF; fm = (r >> 44) & 64'hFFFFF; fa = (a >> 12) & 64'hFFFFF;
               if ((fa & fm) == (fb & fm)) begin
                  h[i] = 1'b1; n = r[33];
                  o = 32'(((fa & ~fm & 64'hFFFFF) << 12) | (a & 32'hFFF));
               end
            end else begin
               fb = (r >> 4) & 64'hFFF; fm = (r >> 36) & 64'hFFF; fa = (a >> 4) & 64'hFFF;
               if ((fa & fm) == (fb & fm)) begin
                  h[i] = 1'b1; n = r[33];
                  o = 32'(((fa & ~fm & 64'hFFF) << 4) | (a & 32'hF));
               end
            end
         end
      end
   endfunction

   // compare with the model on every falling edge
   always @(negedge clk) begin
      logic [3:0] eh; logic en; logic [31:0] eo;
      if (started && !done) begin
         predict(host_addr, host_space, eh, en, eo);
         n_checks++;
         if (cs_hit !== eh || cs_nand !== en || win_offset !== eo) begin
            n_fails++;
            $display("FAIL %s model: hit=%b nand=%b off=%h expected hit=%b nand=%b off=%h",
                     cur_req, cs_hit, cs_nand, win_offset, eh, en, eo);
         end
      end
   end

   function automatic logic [63:0] mem_win(input bit on, input bit nd, input logic [19:0] base,
                                           input logic [19:0] msk);
      return {msk, 9'b0, 1'b1, nd, on, base, 12'b0};
   endfunction

   function automatic logic [63:0] io_win(input bit on, input bit nd, input logic [11:0] base,
                                          input logic [11:0] msk);
      return {16'b0, msk, 1'b0, 1'b0, nd, on, 16'b0, base, 4'b0};
   endfunction

   task automatic write_win(input logic [1:0] idx, input logic [63:0] d);
      @(posedge clk); #2;
      wr_en = 1'b1; wr_idx = idx; wr_data = d;
      @(posedge clk); #2;
      wr_en = 1'b0;
   endtask

   task automatic probe(input logic [31:0] a, input logic sp);
      @(posedge clk); #2;
      host_addr = a; host_space = sp;
      @(negedge clk); #1;
   endtask

   task automatic expect_out(input string req, input logic [3:0] h, input logic n,
                             input logic [31:0] o);
      n_checks++;
      if (cs_hit !== h || cs_nand !== n || win_offset !== o) begin
         n_fails++;
         $display("FAIL %s: hit=%b nand=%b off=%h expected hit=%b nand=%b off=%h",
                  req, cs_hit, cs_nand, win_offset, h, n, o);
      end
   endtask

   task automatic finish_run();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1 reset state
      cur_req = "R1";
      probe(32'h0000_0000, 1'b1); expect_out("R1", 4'b0, 1'b0, 32'h0);
      probe(32'h1234_5678, 1'b0); expect_out("R1", 4'b0, 1'b0, 32'h0);

      // R2 disabled window
      cur_req = "R2";
      write_win(2'd0, mem_win(0, 1, 20'h12345, 20'hFFFFF));
      probe(32'h1234_5678, 1'b1); expect_out("R2", 4'b0, 1'b0, 32'h0);

      // R10 write takes effect, R4 R8 R7 memory decode
      cur_req = "R10";
      write_win(2'd0, mem_win(1, 1, 20'h12345, 20'hFFFFF));
      probe(32'h1234_5678, 1'b1); expect_out("R10", 4'b0001, 1'b1, 32'h0000_0678);

      // R3 wrong space
      cur_req = "R3";
      probe(32'h1234_5678, 1'b0); expect_out("R3", 4'b0, 1'b0, 32'h0);

      // R4 R8 partial mask, NOR device
      cur_req = "R4";
      write_win(2'd1, mem_win(1, 0, 20'hABC00, 20'hFFF00));
      probe(32'hABCD_E123, 1'b1); expect_out("R8", 4'b0010, 1'b0, 32'h000D_E123);
      probe(32'hABDD_E123, 1'b1); expect_out("R4", 4'b0, 1'b0, 32'h0);

      // R5 R9 IO decode, upper address ignored
      cur_req = "R5";
      write_win(2'd2, io_win(1, 1, 12'h010, 12'hFF0));
      probe(32'h0000_01F3, 1'b0); expect_out("R9", 4'b0100, 1'b1, 32'h0000_00F3);
      probe(32'hFFFF_01F3, 1'b0); expect_out("R5", 4'b0100, 1'b1, 32'h0000_00F3);
      probe(32'h0000_0203, 1'b0); expect_out("R5", 4'b0, 1'b0, 32'h0);
      probe(32'h0000_01F3, 1'b1); expect_out("R3", 4'b0, 1'b0, 32'h0);

      // R6 R7 overlapping windows, lowest wins
      cur_req = "R6";
      write_win(2'd3, mem_win(1, 1, 20'hABC00, 20'hFF000));
      probe(32'hABCD_E123, 1'b1); expect_out("R6", 4'b0010, 1'b0, 32'h000D_E123);
      write_win(2'd1, mem_win(0, 0, 20'hABC00, 20'hFFF00));
      probe(32'hABCD_E123, 1'b1); expect_out("R7", 4'b1000, 1'b1, 32'h00CD_E123);

      // R10 strobe low leaves window 0 in place; other windows untouched
      cur_req = "R10";
      @(posedge clk); #2; wr_idx = 2'd0; wr_data = 64'h0; wr_en = 1'b0;
      probe(32'h1234_5678, 1'b1); expect_out("R10", 4'b0001, 1'b1, 32'h0000_0678);
      probe(32'h0000_01F3, 1'b0); expect_out("R10", 4'b0100, 1'b1, 32'h0000_00F3);

      // R6 R4 R5 random mix, checked against the model on every clock
      cur_req = "R6";
      for (int c = 0; c < 600; c++) begin
         @(posedge clk); #2;
         if ($urandom_range(0, 3) == 0) begin
            logic [19:0] b; logic [19:0] m;
            b = 20'($urandom_range(0, 3)) << 16;
            case ($urandom_range(0, 2))
               0: m = 20'hFFFFF;
               1: m = 20'hF0000;
               default: m = 20'h0;
            endcase
            wr_en = 1'b1; wr_idx = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 1) == 1)
               wr_data = mem_win(1'($urandom_range(0, 3) != 0), 1'($urandom), b, m);
            else
               wr_data = io_win(1'($urandom_range(0, 3) != 0), 1'($urandom), b[19:8], m[19:8]);
         end else begin
            wr_en = 1'b0;
         end
         host_addr  = {2'($urandom_range(0, 3)), 14'($urandom), 16'($urandom)};
         if ($urandom_range(0, 1) == 1) host_addr[15:14] = 2'($urandom_range(0, 3));
         host_space = 1'($urandom);
      end
      @(posedge clk); #2; wr_en = 1'b0;
      @(negedge clk); #1;
      finish_run();
   end
endmodule